// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

The block gathers three peripheral conditions (transmitter ready, receive FIFO full and counter ready) into one status byte. An 8-bit mask register decides which of those bits may pull down a single active-low interrupt request. Software can always read the unmasked status through a small register port. Through the same port it writes the mask and reads or writes an 8-bit vector register.

When the processor runs an interrupt acknowledge cycle, the block answers only if its request is currently asserted. In that case it raises a vector-valid strobe and presents the vector byte. Otherwise the vector data stays at zero and the strobe stays low, which lets other requesters share the acknowledge. The receive-full and counter-ready bits are held flags with their own set and clear events. The transmitter-ready bit follows its input directly.

Top module: `vec_intc`

## Requirements
- R1: If any status bit and its mask bit are both 1 at a clock edge, `irq_no` is 0 after that edge.
- R2: If no status bit has a set mask bit at a clock edge, `irq_no` is 1 after that edge, whatever the unmasked status bits hold.
- R3: A read at address 5 returns the raw status byte regardless of the mask. The layout is bit 0 transmitter ready, bit 1 receive full and bit 3 counter ready; all other bits read 0.
- R4: A write at address 5 loads the mask. The mask resets to 0x00, so `irq_no` is 1 out of reset.
- R5: The vector register resets to 0x0F. It is written and read at address 12.
- R6: While `iack_i` is 1 and `irq_no` is 0, `ack_valid_o` is 1 and `ack_data_o` equals the vector register, in the same cycle.
- R7: While `ack_valid_o` is 0, `ack_data_o` is 0x00. `ack_valid_o` is 0 whenever `iack_i` is 0 or `irq_no` is 1.
- R8: Status bit 1 sets on an edge where `rx_load_i` and `rx_fifo_full_i` are both 1. It clears on an edge with `rx_hold_rd_i` at 1. If both events fall on the same edge, the set wins.
- R9: Status bit 3 sets on an edge with `ctr_tick_i` at 1 and clears on an edge with `ctr_stop_i` at 1. If both fall on the same edge, the clear wins.
- R10: Status bit 0 follows `tx_rdy_i` combinationally, with no register between the input and the read data.
- R11: Reads at any address other than 5 and 12 return 0x00. Writes to any other address change neither the mask nor the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tx_rdy_i | input | 1 | Transmitter ready level |
| rx_load_i | input | 1 | Character moved into receive FIFO |
| rx_fifo_full_i | input | 1 | Receive FIFO full level |
| rx_hold_rd_i | input | 1 | Receive holding register read |
| ctr_tick_i | input | 1 | Counter/timer ready event |
| ctr_stop_i | input | 1 | Counter stop command |
| iack_i | input | 1 | Interrupt acknowledge cycle in progress |
| irq_no | output | 1 | Interrupt request, active low |
| ack_valid_o | output | 1 | Vector driven for this acknowledge |
| ack_data_o | output | 8 | Vector byte, zero when not valid |

## Verification
The hardest cases to reach are the simultaneous events on the held flags. One is a FIFO load that refills the FIFO on the same edge as a holding-register read. The other is a counter tick on the same edge as a stop command. The bench drives both pulse pairs in one cycle and reads the status byte back to confirm which event won. A second hard case is an acknowledge that arrives just after the request has dropped. The bench keeps `iack_i` high while it clears the only masked source, then checks that the strobe falls and the vector data returns to zero.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 8;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_VEC  = 4'd12;
  localparam logic [DATA_W-1:0] VEC_RST   = 8'h0F;
  localparam logic [DATA_W-1:0] MASK_RST  = 8'h00;
  localparam int unsigned BIT_TX  = 0;
  localparam int unsigned BIT_RX  = 1;
  localparam int unsigned BIT_CTR = 3;
endpackage

// File: rtl/vec_intc_status.sv
module vec_intc_status
  import vec_intc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_rdy_i,
  input  logic              rx_load_i,
  input  logic              rx_fifo_full_i,
  input  logic              rx_hold_rd_i,
  input  logic              ctr_tick_i,
  input  logic              ctr_stop_i,
  output logic [DATA_W-1:0] stat_o
);
  logic rx_q, ctr_q;

  // set has priority: a read and a refilling load on one edge leave it full
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           rx_q <= 1'b0;
    else if (rx_load_i && rx_fifo_full_i)  rx_q <= 1'b1;
    else if (rx_hold_rd_i)                 rx_q <= 1'b0;
  end

  // stop command has priority over a tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctr_q <= 1'b0;
    else if (ctr_stop_i) ctr_q <= 1'b0;
    else if (ctr_tick_i) ctr_q <= 1'b1;
  end

  always_comb begin
    stat_o          = '0;
    stat_o[BIT_TX]  = tx_rdy_i;
    stat_o[BIT_RX]  = rx_q;
    stat_o[BIT_CTR] = ctr_q;
  end
endmodule

// File: rtl/vec_intc_regs.sv
module vec_intc_regs
  import vec_intc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] stat_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] vec_o
);
  logic sel_stat, sel_vec;

  assign sel_stat = (addr_i == ADDR_STAT);
  assign sel_vec  = (addr_i == ADDR_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               mask_o <= MASK_RST;
    else if (wr_i && sel_stat) mask_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              vec_o <= VEC_RST;
    else if (wr_i && sel_vec) vec_o <= wdata_i;
  end

  // status address reads raw status; the mask is write-only
  always_comb begin
    rdata_o = '0;
    if (sel_stat)     rdata_o = stat_i;
    else if (sel_vec) rdata_o = vec_o;
  end
endmodule

// File: rtl/vec_intc_req.sv
module vec_intc_req
  import vec_intc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] stat_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] vec_i,
  input  logic              iack_i,
  output logic              irq_no,
  output logic              ack_valid_o,
  output logic [DATA_W-1:0] ack_data_o
);
  logic pend;

  assign pend = |(stat_i & mask_i);

  // registered request keeps the pin glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_no <= 1'b1;
    else         irq_no <= ~pend;
  end

  assign ack_valid_o = iack_i & ~irq_no;
  assign ack_data_o  = ack_valid_o ? vec_i : '0;
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tx_rdy_i,
  input  logic              rx_load_i,
  input  logic              rx_fifo_full_i,
  input  logic              rx_hold_rd_i,
  input  logic              ctr_tick_i,
  input  logic              ctr_stop_i,
  input  logic              iack_i,
  output logic              irq_no,
  output logic              ack_valid_o,
  output logic [DATA_W-1:0] ack_data_o
);
  logic [DATA_W-1:0] stat, mask, vec;

  vec_intc_status u_status (
    .clk_i, .rst_ni, .tx_rdy_i, .rx_load_i, .rx_fifo_full_i,
    .rx_hold_rd_i, .ctr_tick_i, .ctr_stop_i, .stat_o(stat)
  );

  vec_intc_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i, .stat_i(stat),
    .rdata_o, .mask_o(mask), .vec_o(vec)
  );

  vec_intc_req u_req (
    .clk_i, .rst_ni, .stat_i(stat), .mask_i(mask), .vec_i(vec),
    .iack_i, .irq_no, .ack_valid_o, .ack_data_o
  );
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk
  import vec_intc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] stat,
  input logic [DATA_W-1:0] mask,
  input logic [DATA_W-1:0] vec,
  input logic              irq_no,
  input logic              iack_i,
  input logic              ack_valid_o,
  input logic [DATA_W-1:0] ack_data_o,
  input logic              rx_load_i,
  input logic              rx_fifo_full_i,
  input logic              rx_hold_rd_i,
  input logic              ctr_tick_i,
  input logic              ctr_stop_i
);
  // R1
  irq_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat & mask)) |=> !irq_no);
  // R2
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(stat & mask)) |=> irq_no);
  // R6
  ack_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && !irq_no) |-> (ack_valid_o && ack_data_o == vec));
  // R7
  ack_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iack_i || irq_no) |-> (!ack_valid_o && ack_data_o == '0));
  // R8
  rx_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_load_i && rx_fifo_full_i) |=> stat[BIT_RX]);
  // R8
  rx_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_hold_rd_i && !(rx_load_i && rx_fifo_full_i)) |=> !stat[BIT_RX]);
  // R9
  ctr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr_stop_i |=> !stat[BIT_CTR]);
  // R9
  ctr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctr_tick_i && !ctr_stop_i) |=> stat[BIT_CTR]);
endmodule

bind vec_intc vec_intc_chk u_chk (
  .clk_i, .rst_ni, .stat, .mask, .vec, .irq_no, .iack_i, .ack_valid_o,
  .ack_data_o, .rx_load_i, .rx_fifo_full_i, .rx_hold_rd_i, .ctr_tick_i,
  .ctr_stop_i
);

// File: tb/vec_intc_tb.sv
`timescale 1ns/1ps
module vec_intc_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic tx_rdy_i = 0, rx_load_i = 0, rx_fifo_full_i = 0, rx_hold_rd_i = 0;
  logic ctr_tick_i = 0, ctr_stop_i = 0, iack_i = 0;
  logic       irq_no, ack_valid_o;
  logic [7:0] ack_data_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  vec_intc u_dut (.*);

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    step();
    wr_i = 1'b0;
  endtask

  function automatic logic [7:0] rd(logic [3:0] a);
    addr_i = a;
    return rdata_o;
  endfunction

  task automatic read_chk(string req, logic [3:0] a, logic [7:0] exp);
    addr_i = a; #0.5;
    check(req, rdata_o, exp);
  endtask

  task automatic t_reset();
    check("R4 irq after reset", {7'b0, irq_no}, 8'h01);
    read_chk("R5 vector reset", 4'd12, 8'h0F);
    read_chk("R3 status reset", 4'd5, 8'h00);
    check("R7 no ack at reset", {7'b0, ack_valid_o}, 8'h00);
  endtask

  task automatic t_tx();
    tx_rdy_i = 1'b1;
    read_chk("R10 tx live", 4'd5, 8'h01);
    step(); step();
    check("R2 unmasked tx", {7'b0, irq_no}, 8'h01);
    wr(4'd5, 8'h01);
    step();
    check("R1 masked tx", {7'b0, irq_no}, 8'h00);
    tx_rdy_i = 1'b0;
    read_chk("R10 tx drop", 4'd5, 8'h00);
    step();
    check("R2 tx gone", {7'b0, irq_no}, 8'h01);
    wr(4'd5, 8'h00);
  endtask

  task automatic t_rx();
    rx_fifo_full_i = 1'b1; rx_load_i = 1'b1; step(); rx_load_i = 1'b0;
    read_chk("R8 rx set", 4'd5, 8'h02);
    rx_hold_rd_i = 1'b1; step(); rx_hold_rd_i = 1'b0;
    read_chk("R8 rx clear", 4'd5, 8'h00);
    rx_load_i = 1'b1; rx_hold_rd_i = 1'b1; step();
    rx_load_i = 1'b0; rx_hold_rd_i = 1'b0;
    read_chk("R8 set wins", 4'd5, 8'h02);
    rx_hold_rd_i = 1'b1; step(); rx_hold_rd_i = 1'b0;
    rx_fifo_full_i = 1'b0; rx_load_i = 1'b1; step(); rx_load_i = 1'b0;
    read_chk("R8 load not full", 4'd5, 8'h00);
  endtask

  task automatic t_ctr();
    ctr_tick_i = 1'b1; step(); ctr_tick_i = 1'b0;
    read_chk("R3 raw status under zero mask", 4'd5, 8'h08);
    step();
    check("R2 ctr unmasked", {7'b0, irq_no}, 8'h01);
    ctr_stop_i = 1'b1; step(); ctr_stop_i = 1'b0;
    read_chk("R9 ctr clear", 4'd5, 8'h00);
    ctr_tick_i = 1'b1; ctr_stop_i = 1'b1; step();
    ctr_tick_i = 1'b0; ctr_stop_i = 1'b0;
    read_chk("R9 clear wins", 4'd5, 8'h00);
  endtask

  task automatic t_ack();
    wr(4'd12, 8'hA5);
    read_chk("R5 vector rw", 4'd12, 8'hA5);
    iack_i = 1'b1; #0.5;
    check("R7 ack no irq valid", {7'b0, ack_valid_o}, 8'h00);
    check("R7 ack no irq data", ack_data_o, 8'h00);
    iack_i = 1'b0;
    wr(4'd5, 8'h08);
    ctr_tick_i = 1'b1; step(); ctr_tick_i = 1'b0;
    step();
    check("R1 ctr masked", {7'b0, irq_no}, 8'h00);
    iack_i = 1'b1; #0.5;
    check("R6 ack valid", {7'b0, ack_valid_o}, 8'h01);
    check("R6 ack data", ack_data_o, 8'hA5);
    ctr_stop_i = 1'b1; step(); ctr_stop_i = 1'b0;
    step();
    check("R7 ack after drop valid", {7'b0, ack_valid_o}, 8'h00);
    check("R7 ack after drop data", ack_data_o, 8'h00);
    iack_i = 1'b0;
  endtask

  task automatic t_other();
    wr(4'd3, 8'hFF);
    read_chk("R11 other read", 4'd3, 8'h00);
    read_chk("R11 vector kept", 4'd12, 8'hA5);
    tx_rdy_i = 1'b1; step(); step();
    check("R11 mask kept", {7'b0, irq_no}, 8'h01);
    tx_rdy_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    t_reset();
    t_tx();
    t_rx();
    t_ctr();
    t_ack();
    t_other();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule